// File: doc/BRIEF.md
# Multifunction Modulo Schedule Controller

This controller drives a loop accelerator whose datapath is shared by several loop kernels. Only one kernel runs at a time. Software first fills a control store with one control word per (kernel, slot) pair and gives each kernel an initiation interval. A control word packs the functional-unit operation codes and the operand-multiplexer selects for one schedule slot. A start pulse then picks a kernel and a run length. From then on a modulo slot counter steps through that kernel's slots and presents the matching control word every cycle.

A run is counted in kernel passes, where one pass equals one initiation interval. Prologue and epilogue passes are part of the count. The datapath enable is high for exactly passes × II cycles. One cycle after the last enabled cycle a single-cycle done pulse appears, and the controller is idle again. The control store has a synchronous read, so it maps onto block RAM. Its read address is computed one cycle ahead, so each word appears in the very cycle it applies to. MAX_SLOTS must be a power of two and NUM_LOOPS at least two.

Top module: `modsched_ctrl`

## Requirements
- R1: After reset, dp_en is 0, done is 0 and slot_idx is 0, and every kernel's initiation interval is 1.
- R2: A start pulse while idle samples loop_sel and iter_count. In the next cycle dp_en is 1, slot_idx is 0 and ctrl_word is the stored word for that kernel at slot 0.
- R3: While dp_en is 1, slot_idx counts 0, 1, ..., II−1 and then wraps to 0, using the II of the running kernel. In every such cycle ctrl_word equals the stored word at (running kernel, slot_idx).
- R4: A written II of 0 behaves as 1, and any II above MAX_SLOTS (16) behaves as 16.
- R5: A run keeps dp_en at 1 for exactly N × II consecutive cycles, where N is the sampled iter_count. An iter_count of 0 behaves as 1.
- R6: done is 1 for exactly one cycle, the cycle right after the last enabled cycle, and dp_en is 0 in that cycle. A start pulse in the done cycle is accepted and begins a new run in the following cycle.
- R7: A start pulse while dp_en is 1 has no effect on the running kernel, its slot sequence or its run length.
- R8: Writes to the control store (cfg_we) and to the II bank (ii_we) while dp_en is 1 are ignored. Later runs still show the previously stored words and II.
- R9: While idle, cfg_we stores cfg_word at (cfg_loop, cfg_slot), and ii_we stores ii_value as the II of kernel ii_loop.
- R10: Rewriting one kernel's words and II leaves every other kernel's words and II unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control-store write strobe, honoured only while idle |
| cfg_loop | input | 2 | Kernel index of the control-store write |
| cfg_slot | input | 4 | Slot index of the control-store write |
| cfg_word | input | 10 | Control word to store |
| ii_we | input | 1 | II write strobe, honoured only while idle |
| ii_loop | input | 2 | Kernel whose II is written |
| ii_value | input | 5 | Initiation interval, 0 treated as 1, above 16 treated as 16 |
| start | input | 1 | Run request, sampled while idle |
| loop_sel | input | 2 | Kernel to run, sampled with start |
| iter_count | input | 16 | Number of kernel passes in the run, 0 treated as 1 |
| dp_en | output | 1 | Datapath enable, high only while running |
| ctrl_word | output | 10 | Control word for the current cycle, valid while dp_en is 1 |
| slot_idx | output | 4 | Current modulo slot |
| done | output | 1 | One-cycle pulse after the last enabled cycle |

## Verification
The hardest situations to reach are the ones that meet at a run boundary. One is a start arriving in the same cycle as the done pulse. Another is a configuration write or a second start landing mid-run, where it could corrupt the active kernel's words or its period. The stimulus chains one run directly into the next by raising start in the done cycle. In a separate run it injects a foreign start, a control-store write and an II write in the second enabled cycle. It then re-runs the same kernel to show that the stored words and the period did not change. Around these cases, every kernel is swept with pass counts of 1, 2 and 0. The kernels have intervals of 4, 8, a written 0 and a written 20, and every enabled cycle is compared with a bench-side table model.

// File: rtl/modsched_pkg.sv
`timescale 1ns/1ps
package modsched_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/modsched_ii_bank.sv
`timescale 1ns/1ps
module modsched_ii_bank #(
  parameter int NUM_LOOPS = 4,
  parameter int MAX_SLOTS = 16,
  parameter int LOOP_W    = 2,
  parameter int SLOT_W    = 4,
  parameter int IIW       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [LOOP_W-1:0] wloop,
  input  logic [IIW-1:0]    wval,
  input  logic [LOOP_W-1:0] rloop,
  output logic [SLOT_W-1:0] rlast
);
  localparam logic [IIW-1:0] MAX_II = IIW'(MAX_SLOTS);
  localparam logic [IIW-1:0] ONE_II = IIW'(1);

  logic [SLOT_W-1:0] last_tbl [NUM_LOOPS];
  logic [SLOT_W-1:0] wlast;

  // store II-1 so the counter compares against the final slot directly
  always_comb begin
    if (wval == '0)         wlast = '0;
    else if (wval > MAX_II) wlast = SLOT_W'(MAX_II - ONE_II);
    else                    wlast = SLOT_W'(wval - ONE_II);
  end

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_ii
    always_ff @(posedge clk) begin
      if (rst)                                 last_tbl[g] <= '0;
      else if (we && (wloop == LOOP_W'(g)))    last_tbl[g] <= wlast;
    end
  end

  assign rlast = last_tbl[rloop];
endmodule

// File: rtl/modsched_ctrl_store.sv
`timescale 1ns/1ps
module modsched_ctrl_store #(
  parameter int DEPTH  = 64,
  parameter int AW     = 6,
  parameter int CTRL_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [CTRL_W-1:0] rdata
);
  logic [CTRL_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/modsched_seq.sv
`timescale 1ns/1ps
module modsched_seq #(
  parameter int SLOT_W = 4,
  parameter int ITER_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SLOT_W-1:0] last_in,
  input  logic [ITER_W-1:0] iters_in,
  output logic              running,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] next_slot,
  output logic              done
);
  import modsched_pkg::*;

  localparam logic [SLOT_W-1:0] ONE_S = SLOT_W'(1);
  localparam logic [ITER_W-1:0] ONE_I = ITER_W'(1);

  run_state_e        state_q;
  logic [SLOT_W-1:0] last_q;
  logic [ITER_W-1:0] pass_q;
  logic [ITER_W-1:0] final_pass_q;
  logic              at_wrap;
  logic              at_end;

  assign running = (state_q == ST_RUN);
  assign at_wrap = (slot_q == last_q);
  assign at_end  = at_wrap && (pass_q == final_pass_q);

  // look-ahead slot: address the store for the cycle after this one
  always_comb begin
    if (running && !at_wrap) next_slot = slot_q + ONE_S;
    else                     next_slot = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      slot_q       <= '0;
      last_q       <= '0;
      pass_q       <= '0;
      final_pass_q <= '0;
      done         <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q      <= ST_RUN;
            slot_q       <= '0;
            pass_q       <= '0;
            last_q       <= last_in;
            final_pass_q <= (iters_in == '0) ? '0 : iters_in - ONE_I;
          end
        end
        ST_RUN: begin
          slot_q <= next_slot;
          if (at_wrap) begin
            if (at_end) begin
              state_q <= ST_IDLE;
              done    <= 1'b1;
            end else begin
              pass_q <= pass_q + ONE_I;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_slot_bound_R3: assert property (@(posedge clk) disable iff (rst)
    running |-> (slot_q <= last_q));

  assert_slot_step_R3: assert property (@(posedge clk) disable iff (rst)
    (running && !at_wrap) |=> (running && (slot_q == $past(slot_q) + ONE_S)));

  assert_pass_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (running && at_wrap && !at_end) |=>
      (running && (slot_q == '0) && (pass_q == $past(pass_q) + ONE_I)));

  assert_finish_R6: assert property (@(posedge clk) disable iff (rst)
    (running && at_end) |=> (!running && done));
endmodule

// File: rtl/modsched_ctrl.sv
`timescale 1ns/1ps
module modsched_ctrl #(
  parameter int NUM_LOOPS = 4,
  parameter int MAX_SLOTS = 16,
  parameter int CTRL_W    = 10,
  parameter int ITER_W    = 16,
  localparam int LOOP_W   = $clog2(NUM_LOOPS),
  localparam int SLOT_W   = $clog2(MAX_SLOTS),
  localparam int IIW      = $clog2(MAX_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [LOOP_W-1:0] cfg_loop,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [CTRL_W-1:0] cfg_word,
  input  logic              ii_we,
  input  logic [LOOP_W-1:0] ii_loop,
  input  logic [IIW-1:0]    ii_value,
  input  logic              start,
  input  logic [LOOP_W-1:0] loop_sel,
  input  logic [ITER_W-1:0] iter_count,
  output logic              dp_en,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              done
);
  localparam int AW    = LOOP_W + SLOT_W;
  localparam int DEPTH = NUM_LOOPS * MAX_SLOTS;

  logic              running;
  logic [SLOT_W-1:0] next_slot;
  logic [SLOT_W-1:0] sel_last;
  logic [LOOP_W-1:0] loop_q;
  logic [LOOP_W-1:0] rd_loop;
  logic              idle_cfg_we;
  logic              idle_ii_we;
  logic              start_ok;

  assign idle_cfg_we = cfg_we && !running;
  assign idle_ii_we  = ii_we && !running;
  assign start_ok    = start && !running;
  assign rd_loop     = running ? loop_q : loop_sel;

  always_ff @(posedge clk) begin
    if (rst)           loop_q <= '0;
    else if (start_ok) loop_q <= loop_sel;
  end

  modsched_ii_bank #(
    .NUM_LOOPS(NUM_LOOPS), .MAX_SLOTS(MAX_SLOTS),
    .LOOP_W(LOOP_W), .SLOT_W(SLOT_W), .IIW(IIW)
  ) ii_bank_i (
    .clk(clk), .rst(rst),
    .we(idle_ii_we), .wloop(ii_loop), .wval(ii_value),
    .rloop(loop_sel), .rlast(sel_last)
  );

  modsched_seq #(.SLOT_W(SLOT_W), .ITER_W(ITER_W)) seq_i (
    .clk(clk), .rst(rst),
    .start(start_ok), .last_in(sel_last), .iters_in(iter_count),
    .running(running), .slot_q(slot_idx), .next_slot(next_slot),
    .done(done)
  );

  modsched_ctrl_store #(.DEPTH(DEPTH), .AW(AW), .CTRL_W(CTRL_W)) store_i (
    .clk(clk),
    .we(idle_cfg_we), .waddr({cfg_loop, cfg_slot}), .wdata(cfg_word),
    .raddr({rd_loop, next_slot}), .rdata(ctrl_word)
  );

  assign dp_en = running;

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !dp_en);

  assert_start_slot0_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !dp_en) |=> (dp_en && (slot_idx == '0)));

  assert_hold_loop_R7: assert property (@(posedge clk) disable iff (rst)
    (dp_en && start) |=> $stable(loop_q));
endmodule

// File: tb/modsched_ctrl_tb.sv
`timescale 1ns/1ps
module modsched_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_loop = '0;
  logic [3:0] cfg_slot = '0;
  logic [9:0] cfg_word = '0;
  logic       ii_we = 1'b0;
  logic [1:0] ii_loop = '0;
  logic [4:0] ii_value = '0;
  logic       start = 1'b0;
  logic [1:0] loop_sel = '0;
  logic [15:0] iter_count = '0;
  logic       dp_en;
  logic [9:0] ctrl_word;
  logic [3:0] slot_idx;
  logic       done;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int tbl [4][16];
  int ii_eff [4];

  always #2.5 clk = ~clk;

  modsched_ctrl dut_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_loop(cfg_loop), .cfg_slot(cfg_slot), .cfg_word(cfg_word),
    .ii_we(ii_we), .ii_loop(ii_loop), .ii_value(ii_value),
    .start(start), .loop_sel(loop_sel), .iter_count(iter_count),
    .dp_en(dp_en), .ctrl_word(ctrl_word), .slot_idx(slot_idx), .done(done)
  );

  function automatic int word_of(int l, int s, int salt);
    return (l * 97 + s * 13 + salt * 211 + 3) & 10'h3FF;
  endfunction

  function automatic int eff_ii(int v);
    if (v == 0) return 1;
    if (v > 16) return 16;
    return v;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_word(int l, int s, int w);
    cfg_we = 1'b1; cfg_loop = 2'(l); cfg_slot = 4'(s); cfg_word = 10'(w);
    tick();
    cfg_we = 1'b0;
    tbl[l][s] = w;
  endtask

  task automatic write_ii(int l, int v);
    ii_we = 1'b1; ii_loop = 2'(l); ii_value = 5'(v);
    tick();
    ii_we = 1'b0;
    ii_eff[l] = eff_ii(v);
  endtask

  task automatic load_loop(int l, int salt, int ii);
    for (int s = 0; s < 16; s++) write_word(l, s, word_of(l, s, salt));
    write_ii(l, ii);
  endtask

  task automatic start_run(int l, int n);
    start = 1'b1; loop_sel = 2'(l); iter_count = 16'(n);
    tick();
    start = 1'b0;
  endtask

  // checks every enabled cycle, then the done cycle; optional mid-run
  // disturbance and optional back-to-back restart in the done cycle
  task automatic run_body(int l, int n, bit inj, bit chain, int nl, int nn);
    int ii = ii_eff[l];
    int np = (n == 0) ? 1 : n;
    for (int k = 0; k < np * ii; k++) begin
      int s = k % ii;
      chk("R5 dp_en high in run", int'(dp_en), 1);
      chk("R3 slot sequence", int'(slot_idx), s);
      chk("R3 ctrl word per slot", int'(ctrl_word), tbl[l][s]);
      chk("R6 no early done", int'(done), 0);
      if (inj && k == 1) begin
        start = 1'b1; loop_sel = 2'((l + 1) % 4); iter_count = 16'd5;
        cfg_we = 1'b1; cfg_loop = 2'(l); cfg_slot = 4'd0; cfg_word = 10'(~tbl[l][0]);
        ii_we = 1'b1; ii_loop = 2'(l); ii_value = 5'd2;
      end else if (inj && k == 2) begin
        start = 1'b0; cfg_we = 1'b0; ii_we = 1'b0;
      end
      tick();
    end
    chk("R6 done pulse", int'(done), 1);
    chk("R6 dp_en low at done", int'(dp_en), 0);
    if (chain) begin
      start = 1'b1; loop_sel = 2'(nl); iter_count = 16'(nn);
      tick();
      start = 1'b0;
      chk("R6 restart from done cycle", int'(dp_en), 1);
    end else begin
      tick();
      chk("R6 done one cycle", int'(done), 0);
      chk("R5 idle after run", int'(dp_en), 0);
    end
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1 reset dp_en", int'(dp_en), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset slot", int'(slot_idx), 0);

    // R1: default II of 1 before any II write
    write_word(0, 0, 10'h155);
    ii_eff[0] = 1;
    start_run(0, 3);
    run_body(0, 3, 1'b0, 1'b0, 0, 0);

    // R9 / R4: load all kernels; II 0 -> 1 and 20 -> 16
    load_loop(0, 0, 4);
    load_loop(1, 0, 8);
    load_loop(2, 0, 0);
    load_loop(3, 0, 20);
    chk("R4 II 0 model", ii_eff[2], 1);
    chk("R4 II clamp model", ii_eff[3], 16);

    // R2 R3 R5: sweep kernels and pass counts (0 behaves as 1)
    for (int l = 0; l < 4; l++) begin
      for (int c = 0; c < 3; c++) begin
        int n = (c == 0) ? 1 : ((c == 1) ? 2 : 0);
        start_run(l, n);
        run_body(l, n, 1'b0, 1'b0, 0, 0);
      end
    end

    // R7 R8: disturb a run, then re-run to show nothing changed
    start_run(1, 2);
    run_body(1, 2, 1'b1, 1'b0, 0, 0);
    start_run(1, 1);
    run_body(1, 1, 1'b0, 1'b0, 0, 0);

    // R6: back-to-back runs started in the done cycle
    start_run(0, 1);
    run_body(0, 1, 1'b0, 1'b1, 2, 3);
    run_body(2, 3, 1'b0, 1'b1, 3, 1);
    run_body(3, 1, 1'b0, 1'b0, 0, 0);

    // R10: rewrite kernel 1 only, other kernels keep their content
    load_loop(1, 1, 5);
    for (int l = 0; l < 4; l++) begin
      start_run(l, 2);
      run_body(l, 2, 1'b0, 1'b0, 0, 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule